// File: doc/BRIEF.md
# Time-State Instruction Controller

This block is the control unit of a small 16-bit accumulator machine with four instructions. It does not give each step of each instruction its own state. Instead, every instruction walks one shared chain of eight time steps, T0 to T7, in order. The two opcode bits of the instruction register and the accumulator sign bit decide two things: which control strobes fire in each step, and where an instruction leaves the chain early to return to T0.

Steps T0 to T2 fetch the instruction. T3 decodes it. T4 and T5 run the operand memory access or the branch, and T6 and T7 finish a load or an add. The two memory steps T1 and T5 hold in place while the memory raises its wait signal. The strobes are decoded directly from the current step, the opcode and the reset state. They drive a datapath that lies outside this block.

Top module: `tsc_ctrl`

## Requirements
- R1: While `rst_n` is low, and for two clock edges after it rises, `tstep` reads 0 and every strobe is 0. Assertion of `rst_n` takes effect at once, without waiting for a clock.
- R2: Fetch runs as follows. In T0, `mem_rd` is 1 and `addr_ir` is 0. In T1, `mem_rd` stays 1 and the controller holds in T1 while `mem_wait` is 1. In T2, `ir_ld` and `pc_inc` are both 1 and the next step is T3.
- R3: Opcodes on `ir_op` (instruction register bits 15:14) are 00 load, 01 store, 10 add and 11 branch-if-negative. In T3, for load, store and add, no strobe fires and the next step is T4.
- R4: A branch with `ac_sign` = 0 in T3 fires no strobe and returns to T0 at the next edge.
- R5: A branch with `ac_sign` = 1 in T3 goes on to T4. T4 raises `pc_ld` alone, and the next step is T0.
- R6: A store raises `mem_wr` and `addr_ir` in T4 and in T5. It holds in T5 while `mem_wait` is 1, then returns to T0.
- R7: A load or an add raises `mem_rd` and `addr_ir` in T4 and in T5, and holds in T5 while `mem_wait` is 1. T6 raises `md_ld`. T7 raises `ac_ld`, with `alu_add` = 1 for an add and 0 for a load. The step after T7 is T0.
- R8: `mem_wait` has no effect in any step other than T1 and T5. Those other steps always advance at the next edge.
- R9: `mem_rd` and `mem_wr` are never both 1, and `pc_inc` and `pc_ld` are never both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| mem_wait | input | 1 | Memory busy; stalls steps T1 and T5 |
| ir_op | input | 2 | Opcode, instruction register bits 15:14 |
| ac_sign | input | 1 | Accumulator bit 15 |
| pc_inc | output | 1 | Increment program counter |
| pc_ld | output | 1 | Load program counter from instruction address field |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| addr_ir | output | 1 | Memory address from instruction (1) or program counter (0) |
| ir_ld | output | 1 | Load instruction register from memory data |
| md_ld | output | 1 | Load memory data register |
| ac_ld | output | 1 | Load accumulator from ALU |
| alu_add | output | 1 | ALU adds (1) or passes memory data (0) |
| tstep | output | 3 | Current time step, 0 to 7 |

## Verification
The hardest situations to reach from the ports are stalls in T5 that last several cycles, because the store path and the load/add path leave T5 differently. Equally hard is a branch whose sign bit must be sampled in exactly the T3 cycle.

The stimulus reaches them in three ways. It draws `mem_wait` and `ac_sign` afresh on every cycle, so long stalls and both branch outcomes occur often. A behavioural instruction register in the bench loads a new random opcode at each `ir_ld`, so every opcode passes through T3 to T7. An asynchronous reset is also applied partway through an instruction, which checks the forced return to T0 and the two-edge release.

// File: rtl/tsc_pkg.sv
`timescale 1ns/1ps
package tsc_pkg;
  localparam int NUM_STEPS = 8;
  localparam int STEP_W    = $clog2(NUM_STEPS);
  localparam int OP_W      = 2;

  typedef enum logic [STEP_W-1:0] {
    T0 = 3'd0, T1 = 3'd1, T2 = 3'd2, T3 = 3'd3,
    T4 = 3'd4, T5 = 3'd5, T6 = 3'd6, T7 = 3'd7
  } tstep_e;

  typedef enum logic [OP_W-1:0] {
    OP_LD  = 2'b00,
    OP_ST  = 2'b01,
    OP_ADD = 2'b10,
    OP_BRN = 2'b11
  } op_e;

  typedef struct packed {
    logic pc_inc;
    logic pc_ld;
    logic mem_rd;
    logic mem_wr;
    logic addr_ir;
    logic ir_ld;
    logic md_ld;
    logic ac_ld;
    logic alu_add;
  } strobe_t;
endpackage

// File: rtl/tsc_rst_sync.sv
`timescale 1ns/1ps
module tsc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  // Assert asynchronously, release after STAGES edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/tsc_seq.sv
`timescale 1ns/1ps
module tsc_seq
  import tsc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_sync_n,
  input  logic     mem_wait,
  input  op_e      op,
  input  logic     ac_sign,
  output tstep_e   step_q
);
  tstep_e step_d;
  logic   mem_step;
  logic   stall;
  logic   adv_en;

  // Steps that talk to memory stall under wait.
  assign mem_step = (step_q == T1) || (step_q == T5);
  assign stall    = mem_step && mem_wait;
  assign adv_en   = !stall;

  always_comb begin
    step_d = step_q;
    case (step_q)
      T0: step_d = T1;
      T1: step_d = T2;
      T2: step_d = T3;
      T3: step_d = (op == OP_BRN && !ac_sign) ? T0 : T4;
      T4: step_d = (op == OP_BRN) ? T0 : T5;
      T5: step_d = (op == OP_ST || op == OP_BRN) ? T0 : T6;
      T6: step_d = T7;
      T7: step_d = T0;
      default: step_d = T0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  step_q <= T0;
    else if (adv_en)  step_q <= step_d;
  end
endmodule

// File: rtl/tsc_decode.sv
`timescale 1ns/1ps
module tsc_decode
  import tsc_pkg::*;
(
  input  logic    live,
  input  tstep_e  step,
  input  op_e     op,
  output strobe_t strb
);
  logic is_ld_add;
  logic is_st;
  logic is_brn;

  assign is_ld_add = (op == OP_LD) || (op == OP_ADD);
  assign is_st     = (op == OP_ST);
  assign is_brn    = (op == OP_BRN);

  always_comb begin
    strb = '0;
    if (live) begin
      case (step)
        T0, T1: strb.mem_rd = 1'b1;
        T2: begin
          strb.ir_ld  = 1'b1;
          strb.pc_inc = 1'b1;
        end
        T3: ;
        T4: begin
          if (is_brn) begin
            strb.pc_ld = 1'b1;
          end else begin
            strb.addr_ir = 1'b1;
            strb.mem_wr  = is_st;
            strb.mem_rd  = is_ld_add;
          end
        end
        T5: begin
          strb.addr_ir = !is_brn;
          strb.mem_wr  = is_st;
          strb.mem_rd  = is_ld_add;
        end
        T6: strb.md_ld = is_ld_add;
        T7: begin
          strb.ac_ld   = is_ld_add;
          strb.alu_add = (op == OP_ADD);
        end
        default: strb = '0;
      endcase
    end
  end
endmodule

// File: rtl/tsc_ctrl.sv
`timescale 1ns/1ps
module tsc_ctrl
  import tsc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mem_wait,
  input  logic [OP_W-1:0]   ir_op,
  input  logic              ac_sign,
  output logic              pc_inc,
  output logic              pc_ld,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              addr_ir,
  output logic              ir_ld,
  output logic              md_ld,
  output logic              ac_ld,
  output logic              alu_add,
  output logic [STEP_W-1:0] tstep
);
  logic    rst_sync_n;
  tstep_e  step_q;
  strobe_t strb;
  op_e     op;

  assign op = op_e'(ir_op);

  tsc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  tsc_seq u_seq (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .mem_wait   (mem_wait),
    .op         (op),
    .ac_sign    (ac_sign),
    .step_q     (step_q)
  );

  tsc_decode u_dec (
    .live (rst_sync_n),
    .step (step_q),
    .op   (op),
    .strb (strb)
  );

  assign pc_inc  = strb.pc_inc;
  assign pc_ld   = strb.pc_ld;
  assign mem_rd  = strb.mem_rd;
  assign mem_wr  = strb.mem_wr;
  assign addr_ir = strb.addr_ir;
  assign ir_ld   = strb.ir_ld;
  assign md_ld   = strb.md_ld;
  assign ac_ld   = strb.ac_ld;
  assign alu_add = strb.alu_add;
  assign tstep   = step_q;
endmodule

// File: rtl/tsc_ctrl_chk.sv
`timescale 1ns/1ps
module tsc_ctrl_chk (
  input logic       clk,
  input logic       rst_live,
  input logic       mem_wait,
  input logic [1:0] ir_op,
  input logic       ac_sign,
  input logic       pc_inc,
  input logic       pc_ld,
  input logic       mem_rd,
  input logic       mem_wr,
  input logic       addr_ir,
  input logic       ir_ld,
  input logic       md_ld,
  input logic       ac_ld,
  input logic       alu_add,
  input logic [2:0] tstep
);
  logic [8:0] all_strb;
  assign all_strb = {pc_inc, pc_ld, mem_rd, mem_wr, addr_ir, ir_ld, md_ld, ac_ld, alu_add};

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_live |-> (all_strb == '0 && tstep == 3'd0));

  assert_fetch_stall_R2: assert property (@(posedge clk) disable iff (!rst_live)
    (tstep == 3'd1 && mem_wait) |=> (tstep == 3'd1));

  assert_ir_ld_next_R2: assert property (@(posedge clk) disable iff (!rst_live)
    ir_ld |=> (tstep == 3'd3));

  assert_brn_skip_R4: assert property (@(posedge clk) disable iff (!rst_live)
    (tstep == 3'd3 && ir_op == 2'b11 && !ac_sign) |=> (tstep == 3'd0));

  assert_brn_taken_R5: assert property (@(posedge clk) disable iff (!rst_live)
    pc_ld |=> (tstep == 3'd0));

  assert_exec_stall_R6: assert property (@(posedge clk) disable iff (!rst_live)
    (tstep == 3'd5 && mem_wait) |=> (tstep == 3'd5));

  assert_add_only_R7: assert property (@(posedge clk) disable iff (!rst_live)
    alu_add |-> (ac_ld && ir_op == 2'b10));

  assert_wait_ignored_R8: assert property (@(posedge clk) disable iff (!rst_live)
    (tstep != 3'd1 && tstep != 3'd5) |=> (tstep != $past(tstep)));

  assert_rw_excl_R9: assert property (@(posedge clk) disable iff (!rst_live)
    !(mem_rd && mem_wr));

  assert_pc_excl_R9: assert property (@(posedge clk) disable iff (!rst_live)
    $onehot0({pc_inc, pc_ld}));
endmodule

bind tsc_ctrl tsc_ctrl_chk u_chk (
  .clk      (clk),
  .rst_live (rst_sync_n),
  .mem_wait (mem_wait),
  .ir_op    (ir_op),
  .ac_sign  (ac_sign),
  .pc_inc   (pc_inc),
  .pc_ld    (pc_ld),
  .mem_rd   (mem_rd),
  .mem_wr   (mem_wr),
  .addr_ir  (addr_ir),
  .ir_ld    (ir_ld),
  .md_ld    (md_ld),
  .ac_ld    (ac_ld),
  .alu_add  (alu_add),
  .tstep    (tstep)
);

// File: tb/tsc_ctrl_tb.sv
`timescale 1ns/1ps
module tsc_ctrl_tb;
  localparam int NCYC = 4000;

  logic clk = 1'b0;
  logic rst_n, mem_wait, ac_sign;
  logic [1:0] ir_op;
  logic pc_inc, pc_ld, mem_rd, mem_wr, addr_ir, ir_ld, md_ld, ac_ld, alu_add;
  logic [2:0] tstep;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tsc_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .mem_wait(mem_wait), .ir_op(ir_op), .ac_sign(ac_sign),
    .pc_inc(pc_inc), .pc_ld(pc_ld), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .addr_ir(addr_ir), .ir_ld(ir_ld), .md_ld(md_ld), .ac_ld(ac_ld),
    .alu_add(alu_add), .tstep(tstep)
  );

  // Reference model state
  int  m_st;
  bit  m_s1, m_s2;
  logic [1:0] m_ir;

  function automatic logic [11:0] expect_vec(int st, logic [1:0] op, bit live);
    bit ldadd, mem;
    logic [11:0] v;
    ldadd = (op == 2'b00) || (op == 2'b10);
    mem   = (st == 4) || (st == 5);
    v[11] = (st == 2);                          // pc_inc
    v[10] = (st == 4) && (op == 2'b11);         // pc_ld
    v[9]  = (st <= 1) || (mem && ldadd);        // mem_rd
    v[8]  = mem && (op == 2'b01);               // mem_wr
    v[7]  = mem && (op != 2'b11);               // addr_ir
    v[6]  = (st == 2);                          // ir_ld
    v[5]  = (st == 6);                          // md_ld
    v[4]  = (st == 7);                          // ac_ld
    v[3]  = (st == 7) && (op == 2'b10);         // alu_add
    v[2:0] = 3'(st);
    if (!live) v = '0;
    return v;
  endfunction

  function automatic string tag_of(int st, logic [1:0] op, bit live, bit w, bit s);
    if (!live) return "R1";
    if (w && st != 1 && st != 5) return "R8";
    if (st <= 2) return "R2";
    if (st == 3) return (op == 2'b11) ? (s ? "R5" : "R4") : "R3";
    if (op == 2'b11) return "R5";
    if (op == 2'b01) return "R6";
    return "R7";
  endfunction

  function automatic int next_step(int st, logic [1:0] op, bit w, bit s);
    case (st)
      0: return 1;
      1: return w ? 1 : 2;
      2: return 3;
      3: return (op == 2'b11 && !s) ? 0 : 4;   // R4 early exit
      4: return (op == 2'b11) ? 0 : 5;          // R5 branch done
      5: if (w) return 5; else return (op == 2'b01) ? 0 : 6;  // R6 / R7
      6: return 7;
      default: return 0;
    endcase
  endfunction

  initial begin
    logic [11:0] exp_v, act_v;
    string tg;
    rst_n = 1'b0; mem_wait = 1'b0; ac_sign = 1'b0; ir_op = 2'b00;
    m_st = 0; m_s1 = 0; m_s2 = 0; m_ir = 2'b00;
    for (int cyc = 0; cyc < NCYC; cyc++) begin
      @(negedge clk);
      rst_n    = !(cyc < 3 || (cyc >= 1700 && cyc < 1703));
      mem_wait = (cyc < 40) ? (cyc % 3 == 1) : (($urandom % 5) < 2);
      ac_sign  = ($urandom % 2) == 1;
      ir_op    = m_ir;
      if (!rst_n) begin m_s1 = 0; m_s2 = 0; m_st = 0; end
      #1;
      exp_v = expect_vec(m_st, m_ir, m_s2);
      act_v = {pc_inc, pc_ld, mem_rd, mem_wr, addr_ir, ir_ld, md_ld, ac_ld, alu_add, tstep};
      tg = tag_of(m_st, m_ir, m_s2, mem_wait, ac_sign);
      checks++;
      if (act_v !== exp_v) begin
        errors++;
        $display("FAIL %s cyc=%0d step=%0d op=%0d actual=%h expected=%h",
                 tg, cyc, m_st, m_ir, act_v, exp_v);
      end
      checks++;  // R9 exclusivity at the ports
      if ((mem_rd && mem_wr) || (pc_inc && pc_ld)) begin
        errors++;
        $display("FAIL R9 cyc=%0d actual rd/wr/inc/ld=%b%b%b%b expected no overlap",
                 cyc, mem_rd, mem_wr, pc_inc, pc_ld);
      end
      @(posedge clk);
      if (m_s2) begin
        if (m_st == 2) m_ir = 2'($urandom % 4);  // bench IR loads at ir_ld
        m_st = next_step(m_st, ir_op, mem_wait, ac_sign);
      end
      m_s2 = m_s1;
      m_s1 = rst_n;
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule